// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block gathers interrupt requests from up to eleven peripheral lines into one pending register and combines that with an enable register to drive a single interrupt line toward the CPU. Each request line is watched for a low-to-high transition. A transition latches the matching pending bit, which stays set until software acknowledges it.

Software reaches both registers over a simple 32-bit register bus: a byte offset, a write strobe, write data and combinational read data. Acknowledge works as an AND mask. A pending bit survives a write only where the written word holds a 1, so software writes the complement of the bits it wants to retire. The enable register is loaded directly. The interrupt line is the OR of every pending bit that is also enabled, so it follows an enable change on the first cycle after the write.

By convention the DMA engine drives request line 3, the serial port drives line 7 and the sound unit drives line 9. In every case request line i feeds pending bit i.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the pending register and the enable register both read 0 and `irq_out` is low.
- R2: A rising edge on `req_in[i]`, sampled at a clock edge, sets pending bit i from that edge onward. A request line held high sets the bit only once. After it is cleared, the bit stays clear until the line falls and rises again.
- R3: A write to offset 0x0 replaces each pending bit with (old bit AND written bit i). A written 0 clears the bit and a written 1 leaves it as it was.
- R4: A write to offset 0x4 loads bits 10..0 of the written word into the enable register.
- R5: `irq_out` is high exactly when some pending bit is also enabled. It changes on the first cycle after the pending or enable write that causes the change.
- R6: If a rising edge on `req_in[i]` is sampled on the same clock edge as a write to offset 0x0 that clears bit i, bit i ends up set.
- R7: Reads return pending at offset 0x0 and enable at offset 0x4 in bits 10..0. Bits 31..11 read 0. Any other offset reads 0, and a write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on `bus_addr` |
| req_in | input | 11 | Peripheral request lines, rising edge sets the pending bit |
| irq_out | output | 1 | Interrupt to the CPU |

## Verification
The hardest case to reach from the ports is a request edge and an acknowledge that clears the same bit landing on the same clock edge. To reach it, the bench raises the request line and presents the clearing write in the same low clock phase, so that both are sampled by one rising edge. It then reads back a set bit. A held-high request line after an acknowledge is the second subtle case. The bench clears the bit while the line is still high and reads the pending register over several later cycles to confirm the bit does not return.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int MAX_SRC  = 32;
  localparam int OFF_PEND = 0;
  localparam int OFF_ENAB = 4;

  typedef logic [MAX_SRC-1:0] src_vec_t;

  // Next pending value: acknowledge is an AND mask, new edges win.
  function automatic src_vec_t pend_next(input src_vec_t old_v,
                                         input logic     ack_we,
                                         input src_vec_t ack_v,
                                         input src_vec_t rise_v);
    src_vec_t kept;
    kept = ack_we ? (old_v & ack_v) : old_v;
    return kept | rise_v;
  endfunction

  // Interrupt request: any pending source that is enabled.
  function automatic logic irq_any(input src_vec_t pend_v,
                                   input src_vec_t enab_v);
    return |(pend_v & enab_v);
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  output logic [NUM_SRC-1:0] rise
);

  logic [NUM_SRC-1:0] req_prev;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev[i] <= 1'b0;
      else        req_prev[i] <= req_in[i];
    end
    assign rise[i] = req_in[i] & ~req_prev[i];
  end

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_data,
  output logic [NUM_SRC-1:0] pend
);

  src_vec_t nxt_full;

  always_comb begin
    nxt_full = pend_next(src_vec_t'(pend), ack_we,
                         src_vec_t'(ack_data), src_vec_t'(rise));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt_full[NUM_SRC-1:0];
  end

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
  import irq_pend_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] enab,
  output logic               we_pend,
  output logic               we_enab,
  output logic [DATA_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(OFF_ENAB);

  logic hit_pend;
  logic hit_enab;

  assign hit_pend = (addr == A_PEND);
  assign hit_enab = (addr == A_ENAB);
  assign we_pend  = we & hit_pend;
  assign we_enab  = we & hit_enab;

  always_comb begin
    rdata = '0;
    if (hit_pend)      rdata[NUM_SRC-1:0] = pend;
    else if (hit_enab) rdata[NUM_SRC-1:0] = enab;
  end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] req_in,
  output logic               irq_out
);

  logic [NUM_SRC-1:0] req_rise;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] enab_q;
  logic [NUM_SRC-1:0] wdata_lo;
  logic               we_pend;
  logic               we_enab;

  assign wdata_lo = bus_wdata[NUM_SRC-1:0];

  irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in (req_in),
    .rise   (req_rise)
  );

  irq_regbus #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .addr    (bus_addr),
    .we      (bus_we),
    .pend    (pend_q),
    .enab    (enab_q),
    .we_pend (we_pend),
    .we_enab (we_enab),
    .rdata   (bus_rdata)
  );

  irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (req_rise),
    .ack_we   (we_pend),
    .ack_data (wdata_lo),
    .pend     (pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enab_q <= '0;
    else if (we_enab) enab_q <= wdata_lo;
  end

  assign irq_out = irq_any(src_vec_t'(pend_q), src_vec_t'(enab_q));

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               we_pend,
  input logic               we_enab,
  input logic [NUM_SRC-1:0] wdata_lo,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] enab,
  input logic               irq_out,
  input logic [DATA_W-1:0]  rdata
);

  // R2 and R6: every sampled edge leaves its bit set, acknowledge or not
  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  // R2: with no edge and no acknowledge the pending register holds
  assert_pend_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_pend && rise == '0) |=> $stable(pend));

  // R3: acknowledge without a competing edge is a plain AND
  assert_ack_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pend && rise == '0) |=> (pend == ($past(pend) & $past(wdata_lo))));

  // R4: enable write loads the written bits
  assert_enab_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_enab |=> (enab == $past(wdata_lo)));

  // R5: interrupt follows enabled pending bits
  assert_irq_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((pend & enab) != '0));

  // R7: unimplemented read bits stay zero
  assert_rd_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NUM_SRC] == '0);

endmodule

bind irq_pend_ctrl irq_pend_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .we_pend  (we_pend),
  .we_enab  (we_enab),
  .wdata_lo (wdata_lo),
  .rise     (req_rise),
  .pend     (pend_q),
  .enab     (enab_q),
  .irq_out  (irq_out),
  .rdata    (bus_rdata)
);

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;

  localparam int NS = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] req_in = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_pend_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_in    (req_in),
    .irq_out   (irq_out)
  );

  task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    expect_val(req, bus_rdata, exp);
  endtask

  // One write sampled at the next rising edge; req_set bits rise on the same edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NS-1:0] req_set);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    req_in    = req_in | req_set;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] lines);
    @(negedge clk);
    req_in = req_in | lines;
    @(negedge clk);
    req_in = req_in & ~lines;
  endtask

  task automatic t_reset;
    rd_check(4'h0, 32'h0, "R1 pending");
    rd_check(4'h4, 32'h0, "R1 enable");
    expect_val("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_edges;
    pulse(11'h288);
    rd_check(4'h0, 32'h288, "R2 dma/serial/sound bits");
    expect_val("R5 masked irq low", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_ack;
    wr(4'h0, 32'hFFFF_FF7F, '0);
    rd_check(4'h0, 32'h208, "R3 clear bit7");
    wr(4'h0, 32'hFFFF_FFFF, '0);
    rd_check(4'h0, 32'h208, "R3 all ones keep");
  endtask

  task automatic t_mask;
    wr(4'h4, 32'h0000_0200, '0);
    expect_val("R5 irq right after enable", {31'b0, irq_out}, 32'h1);
    rd_check(4'h4, 32'h200, "R4 enable readback");
    wr(4'h4, 32'hFFFF_FFFF, '0);
    rd_check(4'h4, 32'h7FF, "R7 upper enable bits zero");
    wr(4'h0, 32'h0, '0);
    expect_val("R5 irq low after ack", {31'b0, irq_out}, 32'h0);
    rd_check(4'h0, 32'h0, "R3 all cleared");
  endtask

  task automatic t_level;
    @(negedge clk);
    req_in[0] = 1'b1;
    rd_check(4'h0, 32'h1, "R2 level sets once");
    wr(4'h0, 32'hFFFF_FFFE, '0);
    repeat (3) @(negedge clk);
    rd_check(4'h0, 32'h0, "R2 held line no reset");
    req_in[0] = 1'b0;
    pulse(11'h001);
    rd_check(4'h0, 32'h1, "R2 new edge sets again");
    wr(4'h0, 32'h0, '0);
  endtask

  task automatic t_race;
    pulse(11'h024);
    rd_check(4'h0, 32'h24, "R2 bits 2 and 5");
    wr(4'h0, 32'h0, 11'h020);
    rd_check(4'h0, 32'h20, "R6 edge beats clear");
    @(negedge clk);
    req_in = '0;
    wr(4'h0, 32'h0, '0);
  endtask

  task automatic t_addr;
    pulse(11'h400);
    wr(4'h4, 32'h0000_0400, '0);
    wr(4'h8, 32'h0, '0);
    rd_check(4'h0, 32'h400, "R7 stray write keeps pending");
    rd_check(4'h4, 32'h400, "R7 stray write keeps enable");
    rd_check(4'h8, 32'h0, "R7 other offset reads zero");
    expect_val("R5 bit10 irq", {31'b0, irq_out}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_ack();
    t_mask();
    t_level();
    t_race();
    t_addr();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule